// File: doc/BRIEF.md
# Framed Serial Register Loader

This block is the write port of a numerically controlled oscillator. A host shifts 16-bit command words into it over three wires: a serial clock, an active-low frame sync and a data line. Each completed word is decoded into a command, an address and a data byte. The block then either keeps the byte in a staging register or commits a write to one of the oscillator's registers. Those registers are two 32-bit frequency words, four phase words, a control field and a select field.

The staging register lets wide values be built from byte-sized payloads. A frequency half-word or a phase word reaches the live register only when its second byte arrives, and both bytes arrive together. Committed writes cross from the serial clock domain into the master clock domain through a toggle handshake. The target register then changes in a single master clock cycle, and the oscillator never sees a half-updated value.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset every output register (both frequency words, all phase words, control and select fields) reads zero.
- R2: While `fsync_n` is low, one bit of `sdata` is taken on each falling edge of `sclk`, most significant bit first. The word is acted upon on the falling edge that delivers its 16th bit.
- R3: A word splits into an operation code in bits 15:12, an address in bits 11:8 and a data byte in bits 7:0. Operation 1 (stage) only loads the data byte into the staging register and changes no output.
- R4: Operation 2 writes the half-word {staging byte, data byte} into a frequency register. Address bit 1 picks the register (0 = `freq0_o`, 1 = `freq1_o`) and address bit 0 picks the half (1 = bits 31:16, 0 = bits 15:0). The other half and all other outputs keep their values.
- R5: Operation 3 writes the low 12 bits of {staging byte, data byte} into phase register n, where n is address bits 1:0. Register n appears on `phase_o[12n+11:12n]`.
- R6: Operation 4 loads data bits 2:0 into `ctrl_o`: bit 2 is sleep, bit 1 is source select and bit 0 is synchronization. No other output changes.
- R7: Operation 5 loads data bits 2:0 into `sel_o`: bit 2 is the frequency select and bits 1:0 are the phase select.
- R8: Operation codes 0 and 6 to 15 change neither the outputs nor the staging register.
- R9: A falling `sclk` edge with `fsync_n` high restarts the bit count. A frame that ends before 16 bits therefore has no effect, and the next full frame decodes correctly.
- R10: The staging byte is kept after a commit, so one staged byte can serve several commits.
- R11: A committed value appears on its output whole, within 4 `mclk` cycles of the falling `sclk` edge that completed the word. The outputs change only when a commit is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, domain of the output registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, data taken on falling edges |
| fsync_n | input | 1 | Frame sync, low during a word |
| sdata | input | 1 | Serial data, MSB first |
| freq0_o | output | 32 | Frequency register 0 |
| freq1_o | output | 32 | Frequency register 1 |
| phase_o | output | 48 | Four 12-bit phase registers, register 0 in the low bits |
| ctrl_o | output | 3 | Control field {sleep, source select, sync} |
| sel_o | output | 3 | Select field {frequency select, phase select[1:0]} |

## Verification
The bench sweeps every combination of operation code and address with changing data bytes, and checks all outputs after each word against a model.

- A decoder that mixes up the address bits would write the wrong frequency half or the wrong phase lane.
- One that clears the staging byte after a commit would write zeros into the upper byte of the second half.
- A shift counter that survives a short frame would misalign the next word and corrupt an unrelated register.
- A handshake that is missing or too slow would leave the old value on the output at the sampling point four master cycles after the word ends.

// File: rtl/sldr_pkg.sv
package sldr_pkg;
  parameter int WORD_W = 16;
  parameter int HALF_W = 16;
  parameter int BYTE_W = 8;
  parameter int OP_W   = 4;
  parameter int ADDR_W = 4;
  parameter int CTRL_W = 3;
  parameter int SEL_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_STAGE = 4'd1,
    OP_FREQ  = 4'd2,
    OP_PHASE = 4'd3,
    OP_CTRL  = 4'd4,
    OP_SEL   = 4'd5
  } op_e;

  typedef enum logic [1:0] {
    TGT_FREQ,
    TGT_PHASE,
    TGT_CTRL,
    TGT_SEL
  } tgt_e;

  typedef struct packed {
    tgt_e                tgt;
    logic [ADDR_W-1:0]   addr;
    logic [HALF_W-1:0]   value;
  } wr_rec_t;
endpackage

// File: rtl/sldr_rst_sync.sv
module sldr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/sldr_frame_rx.sv
module sldr_frame_rx
  import sldr_pkg::*;
#(
  parameter int WORD_BITS = WORD_W
) (
  input  logic                 sclk_i,
  input  logic                 rst_ni,
  input  logic                 fsync_ni,
  input  logic                 sdata_i,
  output logic                 word_done_o,
  output logic [WORD_BITS-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [WORD_BITS-2:0] sh_q, sh_d;

  assign word_o      = {sh_q, sdata_i};
  assign word_done_o = !fsync_ni && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (fsync_ni) begin
      cnt_d = '0;
    end else begin
      sh_d  = word_o[WORD_BITS-2:0];
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  AST_IDLE_RESTART: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    fsync_ni |=> (cnt_q == '0)); // R9
  AST_BIT_ADVANCE: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (!fsync_ni && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/sldr_decode.sv
module sldr_decode
  import sldr_pkg::*;
(
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              word_done_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              tog_o,
  output wr_rec_t           rec_o
);
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] data;

  logic [BYTE_W-1:0] dfr_q, dfr_d;
  logic              tog_q, tog_d;
  wr_rec_t           rec_q, rec_d;

  assign op   = word_i[WORD_W-1 -: OP_W];
  assign addr = word_i[BYTE_W +: ADDR_W];
  assign data = word_i[BYTE_W-1:0];

  always_comb begin
    dfr_d = dfr_q;
    tog_d = tog_q;
    rec_d = rec_q;
    if (word_done_i) begin
      case (op)
        OP_STAGE: dfr_d = data;
        OP_FREQ: begin
          rec_d = '{tgt: TGT_FREQ, addr: addr, value: {dfr_q, data}};
          tog_d = ~tog_q;
        end
        OP_PHASE: begin
          rec_d = '{tgt: TGT_PHASE, addr: addr, value: {dfr_q, data}};
          tog_d = ~tog_q;
        end
        OP_CTRL: begin
          rec_d = '{tgt: TGT_CTRL, addr: addr, value: {{(HALF_W-BYTE_W){1'b0}}, data}};
          tog_d = ~tog_q;
        end
        OP_SEL: begin
          rec_d = '{tgt: TGT_SEL, addr: addr, value: {{(HALF_W-BYTE_W){1'b0}}, data}};
          tog_d = ~tog_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dfr_q <= '0;
      tog_q <= 1'b0;
      rec_q <= '0;
    end else begin
      dfr_q <= dfr_d;
      tog_q <= tog_d;
      rec_q <= rec_d;
    end
  end

  assign tog_o = tog_q;
  assign rec_o = rec_q;

  AST_STAGE_NO_XFER: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (word_done_i && op == OP_STAGE) |=> $stable(tog_o)); // R3
  AST_COMMIT_XFER: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (word_done_i && (op == OP_FREQ || op == OP_PHASE || op == OP_CTRL || op == OP_SEL))
    |=> (tog_o != $past(tog_o))); // R11
  AST_BAD_OP_IGNORED: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (word_done_i && (op == OP_NOP || op > OP_SEL)) |=> ($stable(tog_o) && $stable(rec_o) && $stable(dfr_q))); // R8
endmodule

// File: rtl/sldr_regfile.sv
module sldr_regfile
  import sldr_pkg::*;
#(
  parameter int PHASE_W     = 12,
  parameter int N_PHASE     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tog_i,
  input  wr_rec_t                    rec_i,
  output logic [2*HALF_W-1:0]        freq0_o,
  output logic [2*HALF_W-1:0]        freq1_o,
  output logic [N_PHASE*PHASE_W-1:0] phase_o,
  output logic [CTRL_W-1:0]          ctrl_o,
  output logic [SEL_W-1:0]           sel_o
);
  localparam int FREQ_W = 2 * HALF_W;
  localparam int PSEL_W = (N_PHASE > 1) ? $clog2(N_PHASE) : 1;

  logic [SYNC_STAGES:0] tsync_q;
  logic                 apply;
  logic [2*FREQ_W-1:0]  freq_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tsync_q <= '0;
    else         tsync_q <= {tsync_q[SYNC_STAGES-1:0], tog_i};
  end

  assign apply = tsync_q[SYNC_STAGES] ^ tsync_q[SYNC_STAGES-1];

  for (genvar f = 0; f < 2; f++) begin : g_freq
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic            we;
      logic [HALF_W-1:0] q, d;
      assign we = apply && rec_i.tgt == TGT_FREQ && rec_i.addr[1] == f[0] && rec_i.addr[0] == h[0];
      always_comb d = we ? rec_i.value : q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
      end
      assign freq_all[f*FREQ_W + h*HALF_W +: HALF_W] = q;
    end
  end

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    logic               we;
    logic [PHASE_W-1:0] q, d;
    assign we = apply && rec_i.tgt == TGT_PHASE && rec_i.addr[PSEL_W-1:0] == PSEL_W'(p);
    always_comb d = we ? rec_i.value[PHASE_W-1:0] : q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end
    assign phase_o[p*PHASE_W +: PHASE_W] = q;
  end

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [SEL_W-1:0]  sel_q, sel_d;

  always_comb begin
    ctrl_d = ctrl_q;
    sel_d  = sel_q;
    if (apply && rec_i.tgt == TGT_CTRL) ctrl_d = rec_i.value[CTRL_W-1:0];
    if (apply && rec_i.tgt == TGT_SEL)  sel_d  = rec_i.value[SEL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      sel_q  <= sel_d;
    end
  end

  assign freq0_o = freq_all[FREQ_W-1:0];
  assign freq1_o = freq_all[2*FREQ_W-1:FREQ_W];
  assign ctrl_o  = ctrl_q;
  assign sel_o   = sel_q;

  logic unused_bits;
  assign unused_bits = ^{rec_i.addr[ADDR_W-1:PSEL_W], rec_i.value[HALF_W-1:PHASE_W]};

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply |=> ($stable(freq_all) && $stable(phase_o) && $stable(ctrl_o) && $stable(sel_o))); // R11
  AST_FREQ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && rec_i.tgt == TGT_FREQ) |=> ($stable(phase_o) && $stable(ctrl_o) && $stable(sel_o))); // R4
  AST_CTRL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply && rec_i.tgt == TGT_CTRL) |=> ($stable(freq_all) && $stable(phase_o) && $stable(sel_o))); // R6
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import sldr_pkg::*;
#(
  parameter int PHASE_W     = 12,
  parameter int N_PHASE     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                       mclk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       fsync_n,
  input  logic                       sdata,
  output logic [2*HALF_W-1:0]        freq0_o,
  output logic [2*HALF_W-1:0]        freq1_o,
  output logic [N_PHASE*PHASE_W-1:0] phase_o,
  output logic [CTRL_W-1:0]          ctrl_o,
  output logic [SEL_W-1:0]           sel_o
);
  logic              sclk_inv;
  logic              m_rst_n, s_rst_n;
  logic              word_done;
  logic [WORD_W-1:0] word;
  logic              tog;
  wr_rec_t           rec;

  assign sclk_inv = ~sclk;

  sldr_rst_sync #(.STAGES(RST_STAGES)) u_mrst (
    .clk_i(mclk), .arst_ni(rst_n), .rst_no(m_rst_n));

  sldr_rst_sync #(.STAGES(RST_STAGES)) u_srst (
    .clk_i(sclk_inv), .arst_ni(rst_n), .rst_no(s_rst_n));

  sldr_frame_rx #(.WORD_BITS(WORD_W)) u_rx (
    .sclk_i(sclk), .rst_ni(s_rst_n), .fsync_ni(fsync_n), .sdata_i(sdata),
    .word_done_o(word_done), .word_o(word));

  sldr_decode u_dec (
    .sclk_i(sclk), .rst_ni(s_rst_n), .word_done_i(word_done), .word_i(word),
    .tog_o(tog), .rec_o(rec));

  sldr_regfile #(.PHASE_W(PHASE_W), .N_PHASE(N_PHASE), .SYNC_STAGES(SYNC_STAGES)) u_rf (
    .clk_i(mclk), .rst_ni(m_rst_n), .tog_i(tog), .rec_i(rec),
    .freq0_o(freq0_o), .freq1_o(freq1_o), .phase_o(phase_o),
    .ctrl_o(ctrl_o), .sel_o(sel_o));
endmodule

// File: tb/serial_reg_loader_bench.sv
`timescale 1ns/1ps
module serial_reg_loader_bench;
  logic        mclk, rst_n, sclk, fsync_n, sdata;
  logic [31:0] freq0_o, freq1_o;
  logic [47:0] phase_o;
  logic [2:0]  ctrl_o, sel_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_freq [2];
  logic [11:0] m_phase [4];
  logic [2:0]  m_ctrl, m_sel;
  logic [7:0]  m_dfr;

  serial_reg_loader u_serial_reg_loader (
    .mclk(mclk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdata(sdata),
    .freq0_o(freq0_o), .freq1_o(freq1_o), .phase_o(phase_o),
    .ctrl_o(ctrl_o), .sel_o(sel_o));

  initial mclk = 1'b0;
  always #2.5 mclk = ~mclk;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "freq0", {32'h0, freq0_o}, {32'h0, m_freq[0]});
    chk(tag, "freq1", {32'h0, freq1_o}, {32'h0, m_freq[1]});
    chk(tag, "phase", {16'h0, phase_o}, {16'h0, m_phase[3], m_phase[2], m_phase[1], m_phase[0]});
    chk(tag, "ctrl", {61'h0, ctrl_o}, {61'h0, m_ctrl});
    chk(tag, "sel", {61'h0, sel_o}, {61'h0, m_sel});
  endtask

  task automatic model(input logic [15:0] w);
    logic [3:0] op;
    logic [3:0] ad;
    logic [7:0] d;
    logic [15:0] hw;
    op = w[15:12]; ad = w[11:8]; d = w[7:0];
    hw = {m_dfr, d};
    case (op)
      4'd1: m_dfr = d;
      4'd2: if (ad[0]) m_freq[ad[1]][31:16] = hw; else m_freq[ad[1]][15:0] = hw;
      4'd3: m_phase[ad[1:0]] = hw[11:0];
      4'd4: m_ctrl = d[2:0];
      4'd5: m_sel = d[2:0];
      default: ;
    endcase
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    fsync_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      sdata = w[15-k];
      #10 sclk = 1'b0;
      #10 sclk = 1'b1;
    end
    fsync_n = 1'b1;
  endtask

  task automatic idle();
    fsync_n = 1'b1;
    repeat (2) begin
      #10 sclk = 1'b0;
      #10 sclk = 1'b1;
    end
    #20;
  endtask

  task automatic send_word(input logic [15:0] w);
    send_bits(w, 16);
    model(w);
    idle();
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b1; fsync_n = 1'b1; sdata = 1'b0;
    m_freq[0] = '0; m_freq[1] = '0;
    for (int i = 0; i < 4; i++) m_phase[i] = '0;
    m_ctrl = '0; m_sel = '0; m_dfr = '0;
    #20;
    repeat (3) begin #10 sclk = 1'b0; #10 sclk = 1'b1; end
    rst_n = 1'b1;
    repeat (4) begin #10 sclk = 1'b0; #10 sclk = 1'b1; end
    #20;
    check_all("R1");

    // R3: staging alone leaves outputs untouched
    send_word(16'h10A5);
    check_all("R3");

    // R11: commit visible 4 mclk cycles after the last falling sclk edge
    send_bits(16'h203C, 16);
    model(16'h203C);
    #10;
    chk("R11", "freq0 latency", {32'h0, freq0_o}, {32'h0, 32'h0000A53C});
    idle();

    // R10: staged byte reused for the upper half
    send_word(16'h2177);
    chk("R10", "freq0 both halves", {32'h0, freq0_o}, {32'h0, 32'hA577A53C});
    check_all("R10");

    // R9: short frame discarded, next frame aligned
    send_bits(16'h24FF, 15);
    idle();
    check_all("R9");
    send_bits(16'h50FF, 7);
    idle();
    send_word(16'h4007);
    chk("R9", "ctrl after short frame", {61'h0, ctrl_o}, {61'h0, 3'b111});
    check_all("R9");

    // sweep over every op/address pair
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      logic [15:0] w;
      d = 8'((i * 29) + 7);
      w = {i[3:0], i[7:4], d};
      send_word(w);
      check_all(tag_of(i[3:0]));
    end

    // R5: distinct lanes
    for (int p = 0; p < 4; p++) begin
      logic [7:0] hi;
      hi = 8'(8'h30 + p * 8'h11);
      send_word({4'd1, 4'd0, hi});
      send_word({4'd3, 4'(p), 8'(8'hC0 + p)});
      chk("R5", "phase lane", {52'h0, phase_o[p*12 +: 12]}, {52'h0, hi[3:0], 8'(8'hC0 + p)});
    end
    check_all("R5");

    // R7 and R4 on the second frequency register
    send_word(16'h5006);
    chk("R7", "sel", {61'h0, sel_o}, {61'h0, 3'b110});
    send_word(16'h10BE);
    send_word(16'h22EF);
    send_word(16'h23CA);
    chk("R4", "freq1", {32'h0, freq1_o}, {32'h0, 32'hBECABEEF});
    check_all("R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule